// File: doc/BRIEF.md
# Fixed-Point to Packed Minifloat Converter

The block turns a signed two's-complement fixed-point number into a small packed floating-point word. The word holds a sign bit, a biased exponent field and a mantissa field. The default widths are 5 exponent bits and 10 mantissa bits. The input has a 32-bit integer part and a 32-bit fraction, so one unit of the input word equals 2^-32. Input and output each use a valid/ready handshake. Every result carries a flag that reports an out-of-range exponent that was saturated.

Conversion takes the magnitude and finds its leading one. A barrel shift normalises the magnitude, and the biased exponent is computed from the position of the leading one. The mantissa is truncated. It is never rounded. Magnitudes too small for the exponent range flush to zero, and no subnormal results are produced. Infinities and NaN are not produced. A two-stage pipeline places each result on the output two clock edges after it is accepted. It sustains one conversion per cycle.

Top module: `fixed_to_minifloat`

## Requirements
- R1: An input of exactly zero gives an all-zero word with the clamp flag low.
- R2: The word is packed as {sign, exponent, mantissa}. The mantissa sits in bits [9:0], the exponent in bits [14:10] and the sign in bit 15. The exponent bias is 2^(EXP_W-1)-1 = 15, so the input 1.0 gives 16'h3C00.
- R3: A negative input is converted from its magnitude, and the sign bit is set. The most negative input is converted with a magnitude of 2^31.
- R4: A magnitude below 1 is normalised by n left shifts to the range [1,2). The exponent field is then 15-n, and the mantissa is the 10 bits that follow the leading one, truncated.
- R5: When n is 15 or more, the exponent and mantissa fields are both zero. The sign bit still follows the input sign, so a tiny negative value gives 16'h8000. An exponent field of zero never comes with a nonzero mantissa.
- R6: A magnitude of at least 1 whose leading one is q places above the binary point has exponent 15+q. Its mantissa is the next 10 bits, truncated.
- R7: When those 10 bits are all ones, the upper normalisation bound of 2-2^-10 applies. For q=0, and for q>0 with any lower bit set, the result takes exponent 16+q and mantissa 0. A magnitude of exactly (2-2^-10)*2^q with q>0 keeps mantissa 10'h3FF and exponent 15+q.
- R8: A biased exponent above 31 saturates the word to exponent 5'h1F and mantissa 10'h3FF, and raises out_clamp. In every other case out_clamp is low. An exponent of exactly 31, for example from 2^16, is not clamped.
- R9: After reset, out_valid is low and in_ready is high. A value accepted on an idle pipeline with out_ready high shows on out_valid after the second clock edge. While out_valid is high and out_ready is low, out_word and out_clamp hold. Whenever out_valid is low, in_ready is high.
- R10: With parameter SIGNED_FMT = 0, the sign bit is always zero and the other fields are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input value is presented |
| in_ready | output | 1 | Block can take an input this cycle |
| in_data | input | INT_W+FRAC_W | Signed fixed-point input with FRAC_W fraction bits |
| out_valid | output | 1 | Result word is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | EXP_W+MAN_W+1 | Packed sign, exponent, mantissa |
| out_clamp | output | 1 | Exponent overflow saturated this result |

## Verification
A wrong leading-one position shows up at once in the exponent field of the same result. A wrong shift amount shows up in the mantissa of that word, which appears two edges after acceptance. The boundary values (2-2^-10 scaled by powers of two, 2^-14 and 2^-15, 2^16 and 2^17) expose off-by-one errors in the bump, flush and clamp decisions on a single output word. A pipeline-enable error either drops or duplicates a stalled word, so every later comparison in the ordered result stream goes out of step.

// File: rtl/fixed_to_minifloat.sv
module fixed_to_minifloat #(
  parameter int INT_W      = 32,
  parameter int FRAC_W     = 32,
  parameter int EXP_W      = 5,
  parameter int MAN_W      = 10,
  parameter bit SIGNED_FMT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [INT_W+FRAC_W-1:0]  in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [EXP_W+MAN_W:0]     out_word,
  output logic                     out_clamp
);
  localparam int IN_W   = INT_W + FRAC_W;
  localparam int PW     = $clog2(IN_W);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam int TAIL_W = IN_W - 1 - MAN_W;

  logic            s1_v, s1_neg;
  logic [IN_W-1:0] s1_mag;
  logic            adv1, adv2;

  assign adv2     = !out_valid || out_ready;
  assign adv1     = !s1_v || adv2;
  assign in_ready = adv1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_neg <= 1'b0;
      s1_mag <= '0;
    end else if (adv1) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_neg <= in_data[IN_W-1];
        s1_mag <= in_data[IN_W-1] ? (~in_data + 1'b1) : in_data;
      end
    end
  end

  logic [PW-1:0]    lead;
  logic [IN_W-1:0]  norm;
  logic [MAN_W-1:0] man_top;
  logic             tail_nz;
  int               e_raw, e_fin;
  logic             bump, sg, clamp;
  logic [EXP_W-1:0] ef;
  logic [MAN_W-1:0] mf;

  always_comb begin
    lead = '0;
    for (int i = 0; i < IN_W; i++)
      if (s1_mag[i]) lead = i[PW-1:0];
  end

  assign norm    = s1_mag << (PW'(IN_W - 1) - lead);
  assign man_top = norm[IN_W-2 -: MAN_W];
  assign tail_nz = |norm[TAIL_W-1:0];
  assign e_raw   = BIAS - FRAC_W + int'({1'b0, lead});

  always_comb begin
    sg    = s1_neg & SIGNED_FMT;
    ef    = '0;
    mf    = '0;
    clamp = 1'b0;
    bump  = 1'b0;
    e_fin = e_raw;
    if (!norm[IN_W-1]) begin
      sg = 1'b0;
    end else if (e_raw > 0) begin
      bump  = (e_raw >= BIAS) && (&man_top) && ((e_raw == BIAS) || tail_nz);
      e_fin = e_raw + int'({1'b0, bump});
      if (e_fin > EMAX) begin
        clamp = 1'b1;
        ef    = '1;
        mf    = '1;
      end else begin
        ef = EXP_W'(e_fin);
        mf = bump ? '0 : man_top;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_clamp <= 1'b0;
    end else if (adv2) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_word  <= {sg, ef, mf};
        out_clamp <= clamp;
      end
    end
  end
endmodule

// File: rtl/fixed_to_minifloat_chk.sv
module fixed_to_minifloat_chk #(
  parameter int EXP_W      = 5,
  parameter int MAN_W      = 10,
  parameter bit SIGNED_FMT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [EXP_W+MAN_W:0] out_word,
  input logic                 out_clamp
);
  AST_CLAMP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_clamp |-> (&out_word[EXP_W+MAN_W-1:MAN_W]) && (&out_word[MAN_W-1:0])); // R8
  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_word[EXP_W+MAN_W-1:MAN_W] == '0) |-> (out_word[MAN_W-1:0] == '0) && !out_clamp); // R5
  AST_UNSIGNED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !SIGNED_FMT |-> !out_word[EXP_W+MAN_W]); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_clamp)); // R9
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9
endmodule

bind fixed_to_minifloat fixed_to_minifloat_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .SIGNED_FMT(SIGNED_FMT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_clamp(out_clamp)
);

// File: tb/fixed_to_minifloat_test.sv
`timescale 1ns/1ps
module fixed_to_minifloat_test;
  localparam int NDIR  = 18;
  localparam int NRAND = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_clamp;
  logic [15:0] out_word;
  logic        u_in_ready, u_out_valid, u_out_clamp;
  logic [15:0] u_out_word;

  always #10 clk = ~clk;

  fixed_to_minifloat uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_clamp(out_clamp));

  fixed_to_minifloat #(.SIGNED_FMT(1'b0)) uut_u (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(u_in_ready),
    .in_data(in_data), .out_valid(u_out_valid), .out_ready(out_ready),
    .out_word(u_out_word), .out_clamp(u_out_clamp));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // {clamp, sign, exp[4:0], man[9:0]}
  function automatic logic [16:0] ref_conv(input logic [63:0] raw);
    logic neg;
    logic [63:0] mag;
    logic [127:0] v, one, bnd, tmp;
    int ex, n, k;
    logic [9:0] man;
    neg = raw[63];
    mag = neg ? (~raw + 64'd1) : raw;
    if (mag == 64'd0) return 17'd0;
    v   = {32'd0, mag, 32'd0};
    one = 128'd1 << 64;
    bnd = 128'd2047 << 54;
    if (v < one) begin
      n = 0;
      while (v < one) begin v = v << 1; n++; end
      if (n >= 15) return {1'b0, neg, 15'd0};
      ex = 15 - n;
    end else if (v >= bnd) begin
      k = 0;
      do begin v = v >> 1; k++; end while (v > bnd);
      ex = 15 + k;
    end else ex = 15;
    if (v < one) man = 10'd0;
    else begin tmp = (v - one) >> 54; man = tmp[9:0]; end
    if (ex > 31) return {1'b1, neg, 5'h1F, 10'h3FF};
    return {1'b0, neg, ex[4:0], man};
  endfunction

  function automatic string tag_of(input logic [63:0] raw, input logic [16:0] e);
    if (raw == 64'd0) return "R1";
    if (e[16]) return "R8";
    if (e[14:10] == 5'd0) return "R5";
    if (raw[63]) return "R3";
    if (e[14:10] < 5'd15) return "R4";
    return "R6";
  endfunction

  logic [63:0] dir_val [NDIR];
  string       dir_tag [NDIR];
  logic [16:0] exp_q[$];
  string       tag_q[$];

  initial begin
    dir_val[0]  = 64'd0;                    dir_tag[0]  = "R1";
    dir_val[1]  = 64'h1_0000_0000;          dir_tag[1]  = "R2";
    dir_val[2]  = -64'h1_0000_0000;         dir_tag[2]  = "R3";
    dir_val[3]  = 64'h8000_0000;            dir_tag[3]  = "R4";
    dir_val[4]  = 64'h4_0000;               dir_tag[4]  = "R4";
    dir_val[5]  = 64'h2_0000;               dir_tag[5]  = "R5";
    dir_val[6]  = -64'h2_0000;              dir_tag[6]  = "R5";
    dir_val[7]  = 64'd1;                    dir_tag[7]  = "R5";
    dir_val[8]  = 64'h3_0000_0000;          dir_tag[8]  = "R6";
    dir_val[9]  = 64'h1_0000_0000 + (64'd513 << 22) + (64'd1 << 21); dir_tag[9] = "R6";
    dir_val[10] = 64'd2047 << 22;           dir_tag[10] = "R7";
    dir_val[11] = 64'd2047 << 23;           dir_tag[11] = "R7";
    dir_val[12] = (64'd2047 << 23) + 64'd1; dir_tag[12] = "R7";
    dir_val[13] = 64'h1_0000_0000_0000;     dir_tag[13] = "R8";
    dir_val[14] = 64'h2_0000_0000_0000;     dir_tag[14] = "R8";
    dir_val[15] = 64'h7FFF_FFFF_FFFF_FFFF;  dir_tag[15] = "R8";
    dir_val[16] = 64'h8000_0000_0000_0000;  dir_tag[16] = "R8";
    dir_val[17] = 64'h1_FFFF_FFFF_FFFF;     dir_tag[17] = "R8";
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int idx, popped;
    bit took;
    logic [63:0] r;
    logic [16:0] e;
    string t;
    void'($urandom(32'd20240821));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R9", "reset in_ready", {31'd0, in_ready}, 32'd1);

    // latency on an idle pipeline
    @(negedge clk);
    in_data = 64'h1_0000_0000; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; #1;
    check(out_valid == 1'b0, "R9", "valid after one edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R9", "valid after two edges", {31'd0, out_valid}, 32'd1);
    check(out_word == 16'h3C00, "R2", "word for 1.0", {16'd0, out_word}, 32'h3C00);
    @(negedge clk);

    idx = 0; popped = 0; took = 0; r = '0; t = "";
    while (popped < NDIR + NRAND && !finished) begin
      @(negedge clk);
      if (!in_valid || took) begin
        if (idx < NDIR + NRAND && ($urandom() % 5) != 0) begin
          if (idx < NDIR) begin
            r = dir_val[idx];
            t = dir_tag[idx];
          end else begin
            r = {$urandom(), $urandom()} >> ($urandom() % 64);
            if ($urandom() % 2) r = -r;
            t = tag_of(r, ref_conv(r));
          end
          in_data = r; in_valid = 1'b1; idx++;
        end else in_valid = 1'b0;
      end
      out_ready = ($urandom() % 4) != 0;
      #1;
      took = in_valid && in_ready;
      if (took) begin
        exp_q.push_back(ref_conv(r));
        tag_q.push_back(t);
      end
      if (out_valid && out_ready) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        popped++;
        check(out_word == e[15:0], t, "word", {16'd0, out_word}, {16'd0, e[15:0]});
        check(out_clamp == e[16], t, "clamp flag", {31'd0, out_clamp}, {31'd0, e[16]});
        check(u_out_valid && u_out_word == {1'b0, e[14:0]}, "R10", "unsigned word",
              {15'd0, u_out_valid, u_out_word}, {16'd1, 1'b0, e[14:0]});
      end
    end
    in_valid = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule